// File: doc/BRIEF.md
# Scalar Execution Core with Controller

This block is a compact processor core. It holds six 8-bit general registers, two 8-bit counters, and a small internal program store. A loader writes instruction words into the store while the core is not running. When the run input goes high, a controller steps through the stored words from address zero. Each instruction passes through four states: fetch, decode, execute and write-back.

Each instruction carries an opcode and three register indices. The operations cover add, multiply, compare, AND, OR, clear and multiply-accumulate. Operands are taken from a mix of registers and counters. A multiply whose product is wider than a register puts its high byte in the register after the destination. Every index that runs past the last register wraps back to register 0. The multiply-accumulate keeps its running sum in the registers that follow the destination.

Execution stops once the last loaded instruction has been written back. A test port lets any register or counter be read directly.

Top module: `scp_core`

## Requirements
- R1: After reset, all six registers and both counters read 0, `cmp_led` is 0 and `halted` is 0.
- R2: While `run` is low in the idle state, nothing executes. A rising `run` starts at address 0, and each instruction takes exactly 4 clock cycles. The program length is one more than the highest address loaded. After the last instruction, `halted` goes high and stays high while `run` stays high. Dropping `run` returns the core to idle.
- R3: The instruction word is `{op[16:9], i[8:6], j[5:3], k[2:0]}`. Operand pairing is chosen by the low two opcode bits: 0 = (Ri, C1), 1 = (Ri, C2), 2 = (Ri, Rj), 3 = (C1, C2). Opcodes 00h to 03h write the 8-bit sum of the pair into Rk.
- R4: Opcodes 08h to 0Bh multiply the pair. The low byte of the product goes to Rk and the high byte goes to R((k+1) mod 6).
- R5: Opcodes 10h to 13h write 0 (equal), 1 (first operand less) or 2 (first operand greater) into Rk. They also set `cmp_led` to 1 when the operands are equal and to 0 otherwise. No other instruction changes `cmp_led`.
- R6: Opcodes 20h to 23h write the AND of the pair into Rk. Opcodes 24h to 26h write the OR of the pair into Rk. Opcode 27h writes C1 OR C2 into C2 and touches no register.
- R7: Opcode 30h clears Ri.
- R8: Opcode 40h is a multiply-accumulate. It forms P = Ri*Rj, using the pre-instruction register values. The low byte of (P low byte + R(k+3)) goes to Rk, and its carry out is kept. The low byte of (P high byte + R(k+4) + carry) goes to R(k+1). The two bits above that byte go to R(k+4). All indices are taken mod 6.
- R9: C1 increments once per executed instruction. C2 also increments once per executed instruction, except under opcode 27h. Any opcode not listed above changes no register and no LED.
- R10: `dbg_sel` values 0 to 5 show registers R0 to R5 on `dbg_data`, value 6 shows C1 and value 7 shows C2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Program store write strobe; honoured in the idle and halted states |
| ld_addr | input | 4 | Program store write address |
| ld_word | input | 17 | Instruction word to write |
| run | input | 1 | Start and keep executing when high |
| dbg_sel | input | 3 | Test read selector |
| dbg_data | output | 8 | Selected register or counter value |
| cmp_led | output | 1 | High when the last compare found its operands equal |
| halted | output | 1 | High once the program has finished |

## Verification
Most faults in this core stay hidden until the program ends. A wrong operand latched in decode, a wrong wrapped index, or a lost MAC carry only becomes visible when the registers are read back after `halted`. Because each result feeds the operands of later instructions, one early error spreads into several final register values.

Controller faults behave differently. They show up as a wrong cycle count to `halted`, or as counter values that disagree with the number of instructions run. A counter that skips or repeats a step shifts every later counter-based operand.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int IDXW = 3;
    localparam int OPW  = 8;
    localparam int IW   = OPW + 3 * IDXW;

    typedef struct packed {
        logic [OPW-1:0]  op;
        logic [IDXW-1:0] ri;
        logic [IDXW-1:0] rj;
        logic [IDXW-1:0] rk;
    } instr_t;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_DECODE, S_EXEC, S_WB, S_HALT
    } state_t;

    localparam logic [5:0]     GRP_ADD = 6'h00;
    localparam logic [5:0]     GRP_MUL = 6'h02;
    localparam logic [5:0]     GRP_CMP = 6'h04;
    localparam logic [5:0]     GRP_AND = 6'h08;
    localparam logic [5:0]     GRP_OR  = 6'h09;
    localparam logic [OPW-1:0] OP_CLR  = 8'h30;
    localparam logic [OPW-1:0] OP_MAC  = 8'h40;

endpackage

// File: rtl/scp_prog_store.sv
module scp_prog_store #(
    parameter int DEPTH = 16,
    parameter int WW    = 17,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [WW-1:0] rdata
);
    logic [WW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/scp_alu.sv
module scp_alu
    import scp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic [DW-1:0]  acc_lo,
    input  logic [DW-1:0]  acc_hi,
    output logic [DW-1:0]  res_k,
    output logic [DW-1:0]  res_k1,
    output logic [DW-1:0]  res_k4,
    output logic           we_k,
    output logic           we_k1,
    output logic           we_k4,
    output logic           clr_i,
    output logic           set_c2,
    output logic           led_we,
    output logic           led_v
);
    logic [2*DW-1:0] prod;
    logic [DW:0]     sum0;
    logic [DW+1:0]   sum1;

    always_comb begin
        prod   = (2*DW)'(a) * (2*DW)'(b);
        sum0   = {1'b0, prod[DW-1:0]} + {1'b0, acc_lo};
        sum1   = (DW+2)'(prod[2*DW-1:DW]) + (DW+2)'(acc_hi) + (DW+2)'(sum0[DW]);
        res_k  = '0;
        res_k1 = '0;
        res_k4 = '0;
        we_k   = 1'b0;
        we_k1  = 1'b0;
        we_k4  = 1'b0;
        clr_i  = 1'b0;
        set_c2 = 1'b0;
        led_we = 1'b0;
        led_v  = 1'b0;
        case (op[7:2])
            GRP_ADD: begin
                res_k = a + b;
                we_k  = 1'b1;
            end
            GRP_MUL: begin
                res_k  = prod[DW-1:0];
                res_k1 = prod[2*DW-1:DW];
                we_k   = 1'b1;
                we_k1  = 1'b1;
            end
            GRP_CMP: begin
                res_k  = (a == b) ? DW'(0) : ((a < b) ? DW'(1) : DW'(2));
                we_k   = 1'b1;
                led_we = 1'b1;
                led_v  = (a == b);
            end
            GRP_AND: begin
                res_k = a & b;
                we_k  = 1'b1;
            end
            GRP_OR: begin
                res_k  = a | b;
                set_c2 = (op[1:0] == 2'd3);
                we_k   = (op[1:0] != 2'd3);
            end
            default: begin
                if (op == OP_CLR) begin
                    clr_i = 1'b1;
                end else if (op == OP_MAC) begin
                    res_k  = sum0[DW-1:0];
                    res_k1 = sum1[DW-1:0];
                    res_k4 = DW'(sum1[DW+1:DW]);
                    we_k   = 1'b1;
                    we_k1  = 1'b1;
                    we_k4  = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/scp_core.sv
module scp_core
    import scp_pkg::*;
#(
    parameter int DW    = 8,
    parameter int NREG  = 6,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [IW-1:0] ld_word,
    input  logic          run,
    input  logic [2:0]    dbg_sel,
    output logic [DW-1:0] dbg_data,
    output logic          cmp_led,
    output logic          halted
);
    typedef struct packed {
        state_t                   st;
        logic [AW-1:0]            pc;
        logic [LW-1:0]            len;
        instr_t                   ir;
        logic [DW-1:0]            a;
        logic [DW-1:0]            b;
        logic [DW-1:0]            acc_lo;
        logic [DW-1:0]            acc_hi;
        logic [DW-1:0]            res_k;
        logic [DW-1:0]            res_k1;
        logic [DW-1:0]            res_k4;
        logic                     we_k;
        logic                     we_k1;
        logic                     we_k4;
        logic                     clr_i;
        logic                     set_c2;
        logic                     led_we;
        logic                     led_v;
        logic [NREG-1:0][DW-1:0]  rf;
        logic [DW-1:0]            c1;
        logic [DW-1:0]            c2;
        logic                     led;
    } core_t;

    core_t q, d;

    function automatic logic [IDXW-1:0] widx(input logic [IDXW-1:0] base, input int off);
        int s;
        s = (int'(base) % NREG + off) % NREG;
        return IDXW'(s);
    endfunction

    logic          idle_like;
    logic [IW-1:0] rd_word;
    logic [DW-1:0] a_res_k, a_res_k1, a_res_k4;
    logic          a_we_k, a_we_k1, a_we_k4, a_clr_i, a_set_c2, a_led_we, a_led_v;
    logic [IDXW-1:0] ii, jj, kk, k1, k3, k4;
    logic [1:0]    pair;
    logic [LW-1:0] ld_end, pc_next;

    assign idle_like = (q.st == S_IDLE) || (q.st == S_HALT);
    assign ld_end    = LW'(ld_addr) + LW'(1);
    assign pc_next   = LW'(q.pc) + LW'(1);

    scp_prog_store #(.DEPTH(DEPTH), .WW(IW)) u_store (
        .clk   (clk),
        .we    (ld_we && idle_like),
        .waddr (ld_addr),
        .wdata (ld_word),
        .raddr (q.pc),
        .rdata (rd_word)
    );

    scp_alu #(.DW(DW)) u_alu (
        .op     (q.ir.op),
        .a      (q.a),
        .b      (q.b),
        .acc_lo (q.acc_lo),
        .acc_hi (q.acc_hi),
        .res_k  (a_res_k),
        .res_k1 (a_res_k1),
        .res_k4 (a_res_k4),
        .we_k   (a_we_k),
        .we_k1  (a_we_k1),
        .we_k4  (a_we_k4),
        .clr_i  (a_clr_i),
        .set_c2 (a_set_c2),
        .led_we (a_led_we),
        .led_v  (a_led_v)
    );

    always_comb begin
        ii   = widx(q.ir.ri, 0);
        jj   = widx(q.ir.rj, 0);
        kk   = widx(q.ir.rk, 0);
        k1   = widx(q.ir.rk, 1);
        k3   = widx(q.ir.rk, 3);
        k4   = widx(q.ir.rk, 4);
        pair = (q.ir.op == OP_MAC) ? 2'd2 : q.ir.op[1:0];
        d    = q;
        if (ld_we && idle_like && (ld_end > q.len)) d.len = ld_end;
        case (q.st)
            S_IDLE: begin
                d.pc = '0;
                if (run && (q.len != '0)) d.st = S_FETCH;
            end
            S_FETCH: begin
                d.ir = instr_t'(rd_word);
                d.st = S_DECODE;
            end
            S_DECODE: begin
                case (pair)
                    2'd0:    begin d.a = q.rf[ii]; d.b = q.c1;     end
                    2'd1:    begin d.a = q.rf[ii]; d.b = q.c2;     end
                    2'd2:    begin d.a = q.rf[ii]; d.b = q.rf[jj]; end
                    default: begin d.a = q.c1;     d.b = q.c2;     end
                endcase
                d.acc_lo = q.rf[k3];
                d.acc_hi = q.rf[k4];
                d.st     = S_EXEC;
            end
            S_EXEC: begin
                d.res_k  = a_res_k;
                d.res_k1 = a_res_k1;
                d.res_k4 = a_res_k4;
                d.we_k   = a_we_k;
                d.we_k1  = a_we_k1;
                d.we_k4  = a_we_k4;
                d.clr_i  = a_clr_i;
                d.set_c2 = a_set_c2;
                d.led_we = a_led_we;
                d.led_v  = a_led_v;
                d.st     = S_WB;
            end
            S_WB: begin
                if (q.clr_i) d.rf[ii] = '0;
                if (q.we_k)  d.rf[kk] = q.res_k;
                if (q.we_k1) d.rf[k1] = q.res_k1;
                if (q.we_k4) d.rf[k4] = q.res_k4;
                if (q.led_we) d.led = q.led_v;
                d.c1 = q.c1 + DW'(1);
                d.c2 = q.set_c2 ? q.res_k : q.c2 + DW'(1);
                if (pc_next >= q.len) begin
                    d.st = S_HALT;
                end else begin
                    d.pc = q.pc + AW'(1);
                    d.st = S_FETCH;
                end
            end
            S_HALT: begin
                if (!run) d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        if (int'(dbg_sel) < NREG) dbg_data = q.rf[dbg_sel];
        else if (dbg_sel == 3'd6) dbg_data = q.c1;
        else                      dbg_data = q.c2;
    end

    assign cmp_led = q.led;
    assign halted  = (q.st == S_HALT);

    state_t        st_q;
    logic [DW-1:0] c1_q;
    assign st_q = q.st;
    assign c1_q = q.c1;
endmodule

// File: rtl/scp_core_chk.sv
module scp_core_chk
    import scp_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          cmp_led,
    input logic          halted,
    input state_t        st_q,
    input logic [DW-1:0] c1_q
);
    // R2: fetch is always followed by decode
    a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_FETCH) |=> (st_q == S_DECODE));

    // R2: finished core stays halted while run remains high
    a_r2_halt_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && run) |=> halted);

    // R9: counter steps by one on every write-back
    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_WB) |=> (c1_q == $past(c1_q) + DW'(1)));

    // R9: counter holds outside write-back
    a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_WB) |=> $stable(c1_q));

    // R5: LED changes only at a write-back
    a_r5_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_WB) |=> $stable(cmp_led));
endmodule

bind scp_core scp_core_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .cmp_led (cmp_led),
    .halted  (halted),
    .st_q    (st_q),
    .c1_q    (c1_q)
);

// File: tb/scp_core_test.sv
module scp_core_test;
    localparam int CLK_T = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_we = 1'b0;
    logic [3:0]  ld_addr = '0;
    logic [16:0] ld_word = '0;
    logic        run = 1'b0;
    logic [2:0]  dbg_sel = '0;
    logic [7:0]  dbg_data;
    logic        cmp_led;
    logic        halted;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [2:0] sel;
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sb[$];
    logic [16:0] prog[$];

    always #(CLK_T/2) clk = ~clk;

    scp_core uut (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_word(ld_word), .run(run), .dbg_sel(dbg_sel),
        .dbg_data(dbg_data), .cmp_led(cmp_led), .halted(halted)
    );

    function automatic logic [16:0] mk(input logic [7:0] op, input int i, input int j, input int k);
        return {op, 3'(i), 3'(j), 3'(k)};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int sel, input int val, input string tag);
        exp_t e;
        e.sel = 3'(sel);
        e.val = 8'(val);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: pops each expected item and compares with the port
    task automatic drain();
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            @(negedge clk);
            dbg_sel = e.sel;
            #1;
            chk(e.tag, int'(dbg_data), int'(e.val));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        run   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load();
        for (int n = 0; n < prog.size(); n++) begin
            @(negedge clk);
            ld_we   = 1'b1;
            ld_addr = 4'(n);
            ld_word = prog[n];
        end
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic go(output int cycles);
        cycles = 0;
        @(negedge clk);
        run = 1'b1;
        while (!halted && cycles < 1000) begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cyc;
        do_reset();
        // R1 reset state, R10 selector mapping
        for (int s = 0; s < 8; s++) push(s, 0, "R1/R10 reset value");
        drain();
        chk("R1 led after reset", int'(cmp_led), 0);
        chk("R1 halted after reset", int'(halted), 0);

        // program A: adds, multiply with wrap, compares
        prog = {};
        prog.push_back(mk(8'hFF, 0, 0, 0));
        prog.push_back(mk(8'h00, 0, 0, 1));
        prog.push_back(mk(8'h00, 1, 0, 2));
        prog.push_back(mk(8'h02, 1, 2, 3));
        prog.push_back(mk(8'h03, 0, 0, 4));
        prog.push_back(mk(8'h00, 4, 0, 4));
        prog.push_back(mk(8'h0A, 4, 4, 5));
        prog.push_back(mk(8'h0A, 5, 4, 5));
        prog.push_back(mk(8'h12, 1, 2, 3));
        prog.push_back(mk(8'h12, 5, 1, 2));
        prog.push_back(mk(8'h13, 0, 0, 1));
        load();
        repeat (8) @(negedge clk);
        dbg_sel = 3'd6;
        #1;
        chk("R2 no execution with run low", int'(dbg_data), 0);
        chk("R2 not halted with run low", int'(halted), 0);
        go(cyc);
        chk("R2 cycles to halt (4 per instruction + start)", cyc, 45);
        chk("R2 halted high", int'(halted), 1);
        push(4, 13, "R3 add chain R4");
        push(0, 8, "R4 multiply high byte wraps to R0");
        push(5, 149, "R4 multiply low byte");
        push(3, 1, "R5 compare less code");
        push(2, 2, "R5 compare greater code");
        push(1, 0, "R5 compare equal code");
        push(6, 11, "R9 C1 after 11 instructions");
        push(7, 11, "R10 C2 readout");
        drain();
        chk("R5 led on equal compare", int'(cmp_led), 1);
        repeat (3) @(negedge clk);
        chk("R2 halted holds while run high", int'(halted), 1);
        run = 1'b0;
        @(negedge clk);
        chk("R2 back to idle on run low", int'(halted), 0);

        // program B: logic ops, 27h, clear, undefined opcode
        do_reset();
        prog = {};
        prog.push_back(mk(8'hFF, 0, 0, 0));
        prog.push_back(mk(8'h00, 0, 0, 1));
        prog.push_back(mk(8'h00, 1, 0, 2));
        prog.push_back(mk(8'h00, 2, 0, 3));
        prog.push_back(mk(8'h22, 2, 3, 4));
        prog.push_back(mk(8'h26, 2, 3, 5));
        prog.push_back(mk(8'h24, 5, 0, 0));
        prog.push_back(mk(8'h20, 3, 0, 0));
        prog.push_back(mk(8'h27, 0, 0, 3));
        prog.push_back(mk(8'h01, 0, 0, 1));
        prog.push_back(mk(8'h30, 4, 0, 0));
        prog.push_back(mk(8'h3F, 0, 0, 2));
        load();
        go(cyc);
        push(0, 6, "R6 AND with counter");
        push(1, 14, "R6 27h result feeds C2 operand");
        push(2, 3, "R9 undefined opcode leaves R2");
        push(3, 6, "R6 27h leaves Rk untouched");
        push(4, 0, "R7 clear Ri");
        push(5, 7, "R6 OR of registers");
        push(6, 12, "R9 C1 count");
        push(7, 11, "R6/R9 C2 after 27h");
        drain();
        chk("R9 undefined opcode leaves led", int'(cmp_led), 0);
        run = 1'b0;

        // program C: multiply-accumulate with carry and index wrap
        do_reset();
        prog = {};
        prog.push_back(mk(8'hFF, 0, 0, 0));
        prog.push_back(mk(8'h00, 0, 0, 0));
        prog.push_back(mk(8'h00, 0, 0, 1));
        prog.push_back(mk(8'h00, 1, 0, 2));
        prog.push_back(mk(8'h00, 2, 0, 3));
        prog.push_back(mk(8'h00, 3, 0, 4));
        prog.push_back(mk(8'h00, 4, 0, 5));
        prog.push_back(mk(8'h02, 5, 5, 3));
        prog.push_back(mk(8'h02, 3, 3, 0));
        prog.push_back(mk(8'h40, 5, 5, 3));
        load();
        go(cyc);
        push(3, 13, "R8 MAC low sum into Rk");
        push(4, 5, "R8 MAC high sum with carry into Rk+1");
        push(1, 0, "R8 MAC overflow into Rk+4 wrapped");
        push(0, 84, "R8 MAC Rk+3 source unchanged");
        push(5, 21, "R8 MAC Ri unchanged");
        push(2, 6, "R3 add chain R2");
        drain();
        run = 1'b0;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule